// File: doc/BRIEF.md
# Multi-length AES key schedule generator

This block turns a 128-, 192- or 256-bit AES cipher key into the complete sequence of 32-bit round-key words. After a one-cycle start pulse it streams one schedule word per clock, each tagged with its index and a valid strobe. A done pulse follows the last word. A round datapath or a schedule store downstream takes the words as they come out. The block does not keep the schedule.

Internally the block keeps a sliding window that holds only the most recent Nk words, where Nk is the key length in 32-bit words. It also keeps a running round constant. The S-box needed for the word substitution is computed from the finite-field inverse and the affine map, so no lookup table is written out. The key bus is always 256 bits wide. Shorter keys sit in its upper bits.

Top module: `aes_key_expander`

## Requirements
- R1: `key_len` selects the key size as 00 = 128-bit (Nk=4, 44 words), 01 = 192-bit (Nk=6, 52 words), 10 = 256-bit (Nk=8, 60 words). The code 11 behaves exactly like 00.
- R2: Schedule words 0 to Nk-1 equal the key words, taken from `key_in[255:224]` downward in 32-bit steps. Bits below the selected key length have no effect on any output.
- R3: For index i >= Nk that is not a multiple of Nk, and not the 256-bit case of R5, the word is w[i-1] XOR w[i-Nk].
- R4: For index i >= Nk that is a multiple of Nk, the word is SubWord(RotWord(w[i-1])) XOR {rc,00,00,00} XOR w[i-Nk]. RotWord moves the most significant byte to the least significant position. The round constant rc starts at 01 and is doubled in GF(2^8) (reduction 1b) at each use. For key 2b7e1516 28aed2a6 abf71588 09cf4f3c, w[4] = a0fafe17 and w[43] = b6630ca6.
- R5: With a 256-bit key, an index i >= 8 with i mod 8 = 4 gives SubWord(w[i-1]) XOR w[i-8], with no rotation and no round constant.
- R6: The valid strobe rises in the cycle after start and stays high for exactly 44, 52 or 60 consecutive cycles. The index output counts 0, 1, 2, ... by one per cycle.
- R7: In the cycle after the last word, done is high for exactly one cycle and valid is low.
- R8: A start pulse while a schedule is streaming abandons it. The new schedule begins at index 0 in the next cycle.
- R9: After reset, valid and done are low and the index output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a schedule |
| key_len | input | 2 | Key size select |
| key_in | input | 256 | Cipher key, left-justified |
| word_out | output | 32 | Current schedule word |
| word_idx | output | 6 | Index of the current word |
| word_valid | output | 1 | word_out and word_idx are meaningful |
| done | output | 1 | One-cycle pulse after the final word |

## Verification
The published 128-bit and 256-bit test keys are run along with a 192-bit key. Together they exercise the three window depths, the rotate-substitute-constant step and the substitute-only step that only 256-bit keys use. A 128-bit key with garbage in the unused low bits shows whether those bits leak into the output. The same key under select code 11 separates the fallback decode from the proper 128-bit decode. A restart issued in the middle of a 256-bit run shows whether stale window or round-constant state survives into a new 128-bit schedule.

// File: rtl/aes_key_expander.sv
module aes_key_expander (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   key_len,
  input  logic [255:0] key_in,
  output logic [31:0]  word_out,
  output logic [5:0]   word_idx,
  output logic         word_valid,
  output logic         done
);
  localparam int WW    = 32;
  localparam int WIN   = 8;
  localparam int IDX_W = 6;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r, t;
    r = 8'h00;
    t = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) r = r ^ t;
      t = xtime(t);
    end
    return r;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] a);
    logic [7:0] inv;
    logic [7:0] e;
    e   = 8'hfe;
    inv = 8'h01;
    for (int k = 7; k >= 0; k--) begin
      inv = gmul(inv, inv);
      if (e[k]) inv = gmul(inv, a);
    end
    return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^
           {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  endfunction

  function automatic logic [WW-1:0] sub_word(input logic [WW-1:0] w);
    return {sbox(w[31:24]), sbox(w[23:16]), sbox(w[15:8]), sbox(w[7:0])};
  endfunction

  logic [3:0]       nk_q;
  logic [IDX_W-1:0] last_q;
  logic [IDX_W-1:0] idx_q;
  logic [2:0]       pos_q;
  logic [7:0]       rc_q;
  logic             busy_q, done_q;
  logic [WW-1:0]    win_q [WIN];

  logic [3:0]       nk_new;
  logic [IDX_W-1:0] last_new;
  logic [WW-1:0]    prev, far, sw_in, sw_out, mixed, fresh, key_word;
  logic [3:0]       kpos;
  logic             in_key, rot_step, sub_step;

  assign nk_new   = (key_len == 2'b01) ? 4'd6 : (key_len == 2'b10) ? 4'd8 : 4'd4;
  assign last_new = (key_len == 2'b01) ? 6'd51 : (key_len == 2'b10) ? 6'd59 : 6'd43;

  assign prev     = win_q[0];
  assign far      = win_q[3'(nk_q - 4'd1)];
  assign rot_step = (pos_q == 3'd0);
  assign sub_step = (nk_q == 4'd8) && (pos_q == 3'd4);
  assign sw_in    = rot_step ? {prev[23:0], prev[31:24]} : prev;
  assign sw_out   = sub_word(sw_in);
  assign mixed    = rot_step ? (sw_out ^ {rc_q, 24'h0}) : sub_step ? sw_out : prev;
  assign fresh    = mixed ^ far;

  assign in_key   = ({2'b00, idx_q} < {4'b0000, nk_q});
  assign kpos     = nk_q - 4'd1 - {1'b0, idx_q[2:0]};
  assign key_word = win_q[kpos[2:0]];

  assign word_out   = in_key ? key_word : fresh;
  assign word_idx   = idx_q;
  assign word_valid = busy_q;
  assign done       = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nk_q   <= 4'd4;
      last_q <= 6'd43;
      idx_q  <= '0;
      pos_q  <= '0;
      rc_q   <= 8'h01;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      for (int k = 0; k < WIN; k++) win_q[k] <= '0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        nk_q   <= nk_new;
        last_q <= last_new;
        idx_q  <= '0;
        pos_q  <= '0;
        rc_q   <= 8'h01;
        busy_q <= 1'b1;
        for (int k = 0; k < WIN; k++) begin
          if (k < int'(nk_new))
            win_q[k] <= key_in[WW*(WIN-int'(nk_new)+k) +: WW];
          else
            win_q[k] <= '0;
        end
      end else if (busy_q) begin
        if (idx_q == last_q) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + 6'd1;
        end
        pos_q <= ({1'b0, pos_q} == nk_q - 4'd1) ? 3'd0 : pos_q + 3'd1;
        if (!in_key) begin
          win_q[0] <= fresh;
          for (int k = 1; k < WIN; k++) win_q[k] <= win_q[k-1];
          if (rot_step) rc_q <= xtime(rc_q);
        end
      end
    end
  end
endmodule

// File: rtl/aes_key_expander_chk.sv
module aes_key_expander_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [1:0]   key_len,
  input logic [255:0] key_in,
  input logic [31:0]  word_out,
  input logic [5:0]   word_idx,
  input logic         word_valid,
  input logic         done
);
  logic [5:0] last_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_c <= 6'd43;
    else if (start) last_c <= (key_len == 2'b01) ? 6'd51 : (key_len == 2'b10) ? 6'd59 : 6'd43;
  end

  AST_START_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> word_valid && word_idx == 6'd0);  // R8

  AST_FIRST_KEY_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> word_out == $past(key_in[255:224]));  // R2

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && !start && word_idx != last_c |=> word_valid && word_idx == $past(word_idx) + 6'd1);  // R6

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && !start && word_idx == last_c |=> done && !word_valid);  // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R7

  AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && word_valid));  // R7
endmodule

bind aes_key_expander aes_key_expander_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .key_len(key_len), .key_in(key_in),
  .word_out(word_out), .word_idx(word_idx), .word_valid(word_valid), .done(done)
);

// File: tb/aes_key_expander_bench.sv
module aes_key_expander_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   key_len = 2'b00;
  logic [255:0] key_in = '0;
  logic [31:0]  word_out;
  logic [5:0]   word_idx;
  logic         word_valid;
  logic         done;

  int total = 0;
  int bad = 0;
  logic [7:0]  sb [256];
  logic [31:0] ref_w [60];
  logic [31:0] got_w [60];

  always #5 clk = ~clk;

  aes_key_expander u_aes_key_expander (
    .clk(clk), .rst_n(rst_n), .start(start), .key_len(key_len), .key_in(key_in),
    .word_out(word_out), .word_idx(word_idx), .word_valid(word_valid), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] rl(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  task automatic build_sbox();
    logic [7:0] p, q;
    p = 8'h01; q = 8'h01;
    do begin
      p = p ^ (p << 1) ^ (p[7] ? 8'h1b : 8'h00);
      q = q ^ (q << 1);
      q = q ^ (q << 2);
      q = q ^ (q << 4);
      if (q[7]) q = q ^ 8'h09;
      sb[p] = q ^ rl(q, 1) ^ rl(q, 2) ^ rl(q, 3) ^ rl(q, 4) ^ 8'h63;
    end while (p != 8'h01);
    sb[0] = 8'h63;
  endtask

  function automatic logic [31:0] subw(input logic [31:0] w);
    return {sb[w[31:24]], sb[w[23:16]], sb[w[15:8]], sb[w[7:0]]};
  endfunction

  function automatic int nk_of(input logic [1:0] s);
    return (s == 2'b01) ? 6 : (s == 2'b10) ? 8 : 4;
  endfunction

  task automatic build_ref(input logic [1:0] s, input logic [255:0] k);
    int nk, n;
    logic [7:0] rc;
    logic [31:0] t;
    nk = nk_of(s);
    n = 4 * (nk + 7);
    rc = 8'h01;
    for (int i = 0; i < n; i++) begin
      if (i < nk) ref_w[i] = k[255 - 32*i -: 32];
      else begin
        t = ref_w[i-1];
        if (i % nk == 0) begin
          t = subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
          rc = {rc[6:0], 1'b0} ^ (rc[7] ? 8'h1b : 8'h00);
        end else if (nk == 8 && i % 8 == 4) t = subw(t);
        ref_w[i] = t ^ ref_w[i-nk];
      end
    end
  endtask

  task automatic run(input logic [1:0] s, input logic [255:0] k, input int stop_after);
    int nk, n, lim;
    string tag;
    nk = nk_of(s);
    n = 4 * (nk + 7);
    build_ref(s, k);
    key_len = s; key_in = k; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lim = (stop_after < n) ? stop_after : n;
    for (int i = 0; i < lim; i++) begin
      if (i < nk) tag = "R2";
      else if (i % nk == 0) tag = "R4";
      else if (nk == 8 && i % 8 == 4) tag = "R5";
      else tag = "R3";
      chk(word_valid === 1'b1 && word_idx === 6'(i), "R6 valid/index", {26'd0, word_idx}, i);
      chk(word_out === ref_w[i], tag, word_out, ref_w[i]);
      got_w[i] = word_out;
      if (i < lim - 1 || lim == n) @(negedge clk);
    end
    if (lim == n) begin
      chk(done === 1'b1 && word_valid === 1'b0, "R7 done after last / R1 length", {30'd0, done, word_valid}, 32'h2);
      @(negedge clk);
      chk(done === 1'b0 && word_valid === 1'b0, "R7 done one cycle", {30'd0, done, word_valid}, 32'h0);
    end
  endtask

  localparam logic [255:0] K128 = {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h0};
  localparam logic [255:0] K192 = {192'h8e73b0f7da0e6452c810f32b809079e562f8ead2522c6b7b, 64'h0};
  localparam logic [255:0] K256 = 256'h603deb1015ca71be2b73aef0857d77811f352c073b6108d72d9810a30914dff4;

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    build_sbox();
    repeat (3) @(negedge clk);
    chk(word_valid === 1'b0 && done === 1'b0 && word_idx === 6'd0, "R9 reset state",
        {24'd0, word_idx, word_valid, done}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    run(2'b00, K128, 100);
    chk(got_w[4] === 32'ha0fafe17, "R4 known w4", got_w[4], 32'ha0fafe17);
    chk(got_w[43] === 32'hb6630ca6, "R4 known w43", got_w[43], 32'hb6630ca6);
    repeat (2) @(negedge clk);
    chk(word_valid === 1'b0, "R6 idle stays low", {31'd0, word_valid}, 32'h0);

    run(2'b01, K192, 100);
    run(2'b10, K256, 100);
    run(2'b11, K128, 100);
    chk(got_w[43] === 32'hb6630ca6, "R1 code 11 as 128-bit", got_w[43], 32'hb6630ca6);
    run(2'b00, K128 | 256'h5a5a_dead_beef_0123_4567_89ab_cdef_f00d, 100);
    chk(got_w[43] === 32'hb6630ca6, "R2 unused key bits ignored", got_w[43], 32'hb6630ca6);

    run(2'b10, K256, 10);
    run(2'b00, K128, 100);
    chk(got_w[4] === 32'ha0fafe17, "R8 restart clean", got_w[4], 32'ha0fafe17);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule